// File: doc/BRIEF.md
# Cache line index invalidate unit

This unit executes the index-based line-invalidate instruction of a direct-mapped, write-back data cache. Each request carries three things: a 32-bit instruction word, the value of the base register it names, and a flag that is high in supervisor mode. The unit adds the sign-extended 16-bit immediate to the base value to form an effective address. It selects a line using only the index bits of that address and clears the line's valid and dirty bits in one clock edge. It does not compare the stored tag and does not examine the dirty bit, so modified data in the line is thrown away. The unit is meant for the start-up sequence after reset, where software walks every index once before using data memory.

The unit holds the per-line tag, valid and dirty bits. Two test ports give access to them. A fill port installs a line with a chosen tag and dirty state. A lookup port reports hit and dirty for any address, so the effect of an invalidate can be seen. A parameter can build the unit with no cache at all. In that case the instruction only completes, and lookups always miss.

Top module: `dcache_idx_inval`

## Requirements
- R1: After reset every lookup misses with `lk_dirty` low, `done` and `priv_exc` are low, and `req_ready` goes high on the first clock edge after reset is released.
- R2: An instruction matches only when bits 5:0 hold 0x33 and bits 26:22 are zero. Bits 21:6 hold the immediate and bits 31:27 hold the base register number, which the unit does not use. The effective address is `req_base` plus the immediate sign-extended to 32 bits. The line index is the address bits directly above the byte offset, which are bits 10:5 with the default 32-byte lines and 64 lines.
- R3: The line at the computed index is invalidated even when its stored tag differs from the address tag, so an address that hit before the invalidate misses afterwards.
- R4: A dirty line is invalidated with no writeback, and its dirty bit is cleared. If the same address is later filled clean, `lk_dirty` stays low.
- R5: Lines at every other index keep their valid, tag and dirty state.
- R6: When a matching instruction is accepted with `req_super` high, `done` is high for exactly the one cycle after acceptance. The invalidated line already misses in that cycle.
- R7: When a matching instruction is accepted with `req_super` low, `priv_exc` is high for the one cycle after acceptance, `done` stays low, and the cache is unchanged.
- R8: An instruction that does not match is ignored. No pulse is produced on `done` or `priv_exc`, and no line changes.
- R9: With `CACHE_PRESENT` = 0, a matching supervisor instruction still produces its `done` pulse. A fill has no effect, and every lookup misses.
- R10: If a fill and an invalidate target the same index on the same edge, the invalidate wins and the line misses afterwards. A fill at a different index on that edge still takes effect.
- R11: A negative immediate subtracts from the base, so an immediate of 0xFFC0 with base 0x2040 invalidates the line for address 0x2000 and not the line for 0x2040.
- R12: `req_ready` stays high out of reset, and back-to-back requests on consecutive cycles each produce their own `done` pulse and their own invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_instr | input | 32 | Instruction word |
| req_base | input | 32 | Base register value |
| req_super | input | 1 | High in supervisor mode |
| done | output | 1 | Invalidate completed, one cycle after acceptance |
| priv_exc | output | 1 | Privilege violation, one cycle after acceptance |
| fl_en | input | 1 | Test fill strobe |
| fl_addr | input | 32 | Test fill address |
| fl_dirty | input | 1 | Dirty state given to the filled line |
| lk_addr | input | 32 | Test lookup address |
| lk_hit | output | 1 | Lookup address is valid and its tag matches |
| lk_dirty | output | 1 | Line at the lookup address is valid and dirty |

## Verification
The assertions take for granted that `req_super`, `req_instr` and `req_base` are stable and known whenever `req_valid` is high. They also assume fill and lookup addresses are never X. The count check on valid bits holds only in cycles with no fill, so the bench raises `fl_en` only inside its own fill task. The one exception is a deliberate same-edge collision. Every input changes at the falling clock edge, and the bench samples combinational lookups a short delay after that edge. The data sampled is therefore settled and away from the rising edge where the state updates.

// File: rtl/dcinv_pkg.sv
package dcinv_pkg;

   localparam logic [5:0] OPC_LINE_INVAL = 6'h33;

   typedef struct packed {
      logic [4:0]  base_reg;
      logic [4:0]  must_zero;
      logic [15:0] imm;
      logic [5:0]  opcode;
   } inval_instr_t;

   function automatic logic [31:0] sext16(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

endpackage

// File: rtl/dcinv_decode.sv
module dcinv_decode
   import dcinv_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 5,
   parameter int IDX_W  = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] base,
   input  logic              super_mode,
   output logic              inval_en,
   output logic              exc_en,
   output logic [IDX_W-1:0]  inval_idx
);
   inval_instr_t      fields;
   logic              is_match;
   logic [ADDR_W-1:0] eff_addr;

   assign fields    = inval_instr_t'(instr);
   assign is_match  = (fields.opcode == OPC_LINE_INVAL) && (fields.must_zero == 5'd0);
   assign eff_addr  = base + ADDR_W'(sext16(fields.imm));
   assign inval_idx = eff_addr[OFS_W +: IDX_W];
   assign inval_en  = accept && is_match && super_mode;
   assign exc_en    = accept && is_match && !super_mode;

   // R8: a word that does not decode must start nothing
   p_bad_op_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && instr[5:0] != OPC_LINE_INVAL) |-> (!inval_en && !exc_en));

   p_user_never_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !super_mode) |-> !inval_en);
endmodule

// File: rtl/dcinv_tagstore.sv
module dcinv_tagstore #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 5,
   parameter int IDX_W  = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval_en,
   input  logic [IDX_W-1:0]  inval_idx,
   input  logic              fill_en,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_dirty,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic              lk_dirty
);
   localparam int LINES = 1 << IDX_W;
   localparam int TAG_W = ADDR_W - OFS_W - IDX_W;

   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   logic [IDX_W-1:0] fill_idx, lk_idx;
   logic [TAG_W-1:0] fill_tag, lk_tag;
   logic             fill_wins;

   assign fill_idx  = fill_addr[OFS_W +: IDX_W];
   assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];
   assign lk_idx    = lk_addr[OFS_W +: IDX_W];
   assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
   // invalidate takes priority over a fill at the same index
   assign fill_wins = fill_en && !(inval_en && inval_idx == fill_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         if (inval_en) begin
            valid_q[inval_idx] <= 1'b0;
            dirty_q[inval_idx] <= 1'b0;
         end
         if (fill_wins) begin
            valid_q[fill_idx] <= 1'b1;
            dirty_q[fill_idx] <= fill_dirty;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_wins) tag_q[fill_idx] <= fill_tag;
   end

   assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   assign lk_dirty = valid_q[lk_idx] && dirty_q[lk_idx];

   p_inval_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      inval_en |=> (!valid_q[$past(inval_idx)] && !dirty_q[$past(inval_idx)]));

   p_no_new_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_en |=> ($countones(valid_q) <= $past($countones(valid_q))));

   p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !inval_en) |=> valid_q[$past(fill_idx)]);
endmodule

// File: rtl/dcache_idx_inval.sv
module dcache_idx_inval #(
   parameter int LINE_BYTES    = 32,
   parameter int LINES         = 64,
   parameter bit CACHE_PRESENT = 1'b1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_instr,
   input  logic [31:0] req_base,
   input  logic        req_super,
   output logic        done,
   output logic        priv_exc,
   input  logic        fl_en,
   input  logic [31:0] fl_addr,
   input  logic        fl_dirty,
   input  logic [31:0] lk_addr,
   output logic        lk_hit,
   output logic        lk_dirty
);
   localparam int ADDR_W = 32;
   localparam int OFS_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(LINES);

   if ((1 << OFS_W) != LINE_BYTES) begin : g_chk_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((1 << IDX_W) != LINES || LINES < 2) begin : g_chk_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (OFS_W + IDX_W >= ADDR_W) begin : g_chk_split
      $error("offset and index leave no tag bits");
   end

   logic             ready_q, done_q, exc_q;
   logic             accept, inval_en, exc_en;
   logic [IDX_W-1:0] inval_idx;

   assign accept = req_valid && ready_q;

   dcinv_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .accept(accept), .instr(req_instr),
      .base(req_base), .super_mode(req_super),
      .inval_en(inval_en), .exc_en(exc_en), .inval_idx(inval_idx)
   );

   if (CACHE_PRESENT) begin : g_cache
      dcinv_tagstore #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_tags (
         .clk(clk), .rst_n(rst_n), .inval_en(inval_en), .inval_idx(inval_idx),
         .fill_en(fl_en), .fill_addr(fl_addr), .fill_dirty(fl_dirty),
         .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_dirty(lk_dirty)
      );
   end else begin : g_nocache
      assign lk_hit   = 1'b0;
      assign lk_dirty = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         done_q  <= 1'b0;
         exc_q   <= 1'b0;
      end else begin
         ready_q <= 1'b1;
         done_q  <= inval_en;
         exc_q   <= exc_en;
      end
   end

   assign req_ready = ready_q;
   assign done      = done_q;
   assign priv_exc  = exc_q;

   p_done_exc_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && priv_exc));

   p_done_follows_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(req_valid && req_super));

   p_exc_follows_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
      priv_exc |-> $past(req_valid && !req_super));
endmodule

// File: tb/dcache_idx_inval_tb_top.sv
module dcache_idx_inval_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_super = 1'b0;
   logic [31:0] req_instr = '0, req_base = '0;
   logic        fl_en = 1'b0, fl_dirty = 1'b0;
   logic [31:0] fl_addr = '0, lk_addr = '0;
   logic        req_ready, done, priv_exc, lk_hit, lk_dirty;
   logic        a_ready, a_done, a_exc, a_hit, a_dirty;
   int          total = 0, bad = 0;

   always #4 clk = ~clk;

   dcache_idx_inval dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_instr(req_instr), .req_base(req_base), .req_super(req_super),
      .done(done), .priv_exc(priv_exc), .fl_en(fl_en), .fl_addr(fl_addr),
      .fl_dirty(fl_dirty), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_dirty(lk_dirty)
   );

   dcache_idx_inval #(.CACHE_PRESENT(1'b0)) absent_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_ready),
      .req_instr(req_instr), .req_base(req_base), .req_super(req_super),
      .done(a_done), .priv_exc(a_exc), .fl_en(fl_en), .fl_addr(fl_addr),
      .fl_dirty(fl_dirty), .lk_addr(lk_addr), .lk_hit(a_hit), .lk_dirty(a_dirty)
   );

   function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] mz,
                                       input logic [15:0] imm);
      return {5'd6, mz, imm, op};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill(input logic [31:0] a, input logic d);
      @(negedge clk); fl_en = 1'b1; fl_addr = a; fl_dirty = d;
      @(negedge clk); fl_en = 1'b0;
   endtask

   task automatic look(input logic [31:0] a, input logic eh, input logic ed, input string req);
      lk_addr = a; #1;
      chk(lk_hit == eh, req, lk_hit, eh);
      chk(lk_dirty == ed, req, lk_dirty, ed);
      chk(a_hit == 1'b0, "R9", a_hit, 0);
   endtask

   task automatic issue(input logic [31:0] ins, input logic [31:0] b, input logic sup,
                        input logic ed, input logic ee, input string req);
      @(negedge clk); req_valid = 1'b1; req_instr = ins; req_base = b; req_super = sup;
      chk(req_ready == 1'b1, "R12", req_ready, 1);
      @(negedge clk); req_valid = 1'b0;
      chk(done == ed, req, done, ed);
      chk(priv_exc == ee, req, priv_exc, ee);
      chk(a_done == ed, "R9", a_done, ed);
      @(negedge clk);
      chk(done == 1'b0, "R6", done, 0);
      chk(priv_exc == 1'b0, "R7", priv_exc, 0);
   endtask

   task automatic t_reset();
      #1;
      look(32'h0, 0, 0, "R1");
      look(32'h0001_2340, 0, 0, "R1");
      chk(done == 0 && priv_exc == 0, "R1", done, 0);
   endtask

   task automatic t_basic();
      fill(32'h0001_2340, 0);
      look(32'h0001_2340, 1, 0, "R2");
      issue(enc(6'h33, 5'd0, 16'h0040), 32'h0001_2300, 1, 1, 0, "R6");
      look(32'h0001_2340, 0, 0, "R2");
   endtask

   task automatic t_tag_ignored();
      fill(32'h0005_0080, 0);
      issue(enc(6'h33, 5'd0, 16'h0080), 32'h7777_0000, 1, 1, 0, "R3");
      look(32'h0005_0080, 0, 0, "R3");
   endtask

   task automatic t_dirty();
      fill(32'h0000_1000, 1);
      look(32'h0000_1000, 1, 1, "R4");
      issue(enc(6'h33, 5'd0, 16'h0000), 32'h0000_1000, 1, 1, 0, "R4");
      look(32'h0000_1000, 0, 0, "R4");
      fill(32'h0000_1000, 0);
      look(32'h0000_1000, 1, 0, "R4");
   endtask

   task automatic t_neighbours();
      fill(32'h0000_0140, 1); fill(32'h0000_0160, 0); fill(32'h0000_0180, 0);
      issue(enc(6'h33, 5'd0, 16'h0000), 32'h0000_0160, 1, 1, 0, "R5");
      look(32'h0000_0160, 0, 0, "R5");
      look(32'h0000_0140, 1, 1, "R5");
      look(32'h0000_0180, 1, 0, "R5");
   endtask

   task automatic t_negative();
      fill(32'h0000_2000, 0); fill(32'h0000_2040, 0);
      issue(enc(6'h33, 5'd0, 16'hFFC0), 32'h0000_2040, 1, 1, 0, "R11");
      look(32'h0000_2000, 0, 0, "R11");
      look(32'h0000_2040, 1, 0, "R11");
   endtask

   task automatic t_user();
      fill(32'h0000_0300, 1);
      issue(enc(6'h33, 5'd0, 16'h0000), 32'h0000_0300, 0, 0, 1, "R7");
      look(32'h0000_0300, 1, 1, "R7");
   endtask

   task automatic t_bad_op();
      issue(enc(6'h34, 5'd0, 16'h0000), 32'h0000_0300, 1, 0, 0, "R8");
      look(32'h0000_0300, 1, 1, "R8");
      issue(enc(6'h33, 5'd1, 16'h0000), 32'h0000_0300, 1, 0, 0, "R8");
      look(32'h0000_0300, 1, 1, "R8");
   endtask

   task automatic t_back_to_back();
      fill(32'h0000_0400, 0); fill(32'h0000_0420, 0);
      @(negedge clk); req_valid = 1; req_super = 1; req_base = 32'h400;
      req_instr = enc(6'h33, 5'd0, 16'h0000);
      @(negedge clk); req_instr = enc(6'h33, 5'd0, 16'h0020);
      chk(done == 1, "R12", done, 1);
      chk(req_ready == 1, "R12", req_ready, 1);
      @(negedge clk); req_valid = 0;
      chk(done == 1, "R12", done, 1);
      @(negedge clk);
      chk(done == 0, "R12", done, 0);
      look(32'h0000_0400, 0, 0, "R12");
      look(32'h0000_0420, 0, 0, "R12");
   endtask

   task automatic t_collision();
      @(negedge clk);
      fl_en = 1; fl_addr = 32'h0000_0500; fl_dirty = 1;
      req_valid = 1; req_super = 1; req_base = 32'h0000_0500;
      req_instr = enc(6'h33, 5'd0, 16'h0000);
      @(negedge clk); fl_en = 0; req_valid = 0;
      chk(done == 1, "R10", done, 1);
      look(32'h0000_0500, 0, 0, "R10");
      @(negedge clk);
      fl_en = 1; fl_addr = 32'h0000_0520; fl_dirty = 0;
      req_valid = 1; req_base = 32'h0000_0500;
      @(negedge clk); fl_en = 0; req_valid = 0;
      look(32'h0000_0520, 1, 0, "R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1 && a_ready == 1, "R1", req_ready, 1);
      t_basic();
      t_tag_ignored();
      t_dirty();
      t_neighbours();
      t_negative();
      t_user();
      t_bad_op();
      t_back_to_back();
      t_collision();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule